// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides, every clock cycle, whether the interrupt level presented on its request input is accepted by the processor. If it is, the block produces the full state update for entering the handler: the new program counter, the new status word, and the writes to the saved-PC, saved-status, double-exception PC and exception-cause registers. The interrupt sources, the register file and the pipeline stay outside the block. The pipeline applies the write strobes and the redirect on the cycle the taken pulse is high.

Levels above 1 each have a dedicated vector and keep their PC and status word in registers owned by that level. A level-1 interrupt is not vectored directly. It becomes a general exception: a double exception when the status word already shows exception mode, and otherwise a user or kernel exception chosen by the user-mode bit. Vectors can optionally be relocated against a run-time vector-base register.

Top module: `irq_entry_top`

## Requirements
- R1: An interrupt at level L is taken only when L is strictly greater than the status-word interrupt-level field (bits 3:0), L is at most NLEVEL, and the slice of `levelMask` for L (bits (L-1)*XLEN and up) has at least one bit that is also set in both `intPending` and `intEnable`.
- R2: On a cycle whose inputs do not satisfy R1, all write strobes and the taken pulse stay low on the following cycle, and `pcOut`, `psOut`, `savedPc`, `savedPs` and `causeOut` keep their values.
- R3: All results are registered. They appear on the clock edge that samples a satisfying input and last one cycle for each taken cycle.
- R4: For L greater than 1, `epcWe` bit L-1 and `epsWe` bit L-2 are set alone, `depcWe` and `causeWe` are low, `savedPc` equals the sampled PC and `savedPs` equals the sampled status word.
- R5: For L greater than 1, `psOut` equals the sampled status word with bits 3:0 replaced by L and bit 4 (exception mode) set.
- R6: For L greater than 1, `pcOut` equals HI_VEC_BASE + (L-2)*VEC_STRIDE, relocated as in R10.
- R7: For L equal to 1, `causeWe` is set and `causeOut` becomes LVL1_CAUSE (default 4). `epsWe` stays zero and `psOut` is the sampled status word with bit 4 set.
- R8: For L equal to 1 with status bit 4 already set, `pcOut` is the relocated DOUBLE_VEC. The PC is saved with `depcWe` when HAS_DEPC is 1, and with `epcWe` bit 0 when HAS_DEPC is 0.
- R9: For L equal to 1 with status bit 4 clear, `epcWe` bit 0 saves the PC. `pcOut` is the relocated USER_VEC when status bit 5 is set and the relocated KERNEL_VEC when it is clear.
- R10: With RELOC_EN set, every vector V is output as V - RESET_VECBASE + `vecBase`. With RELOC_EN clear, V is output unchanged and `vecBase` has no effect.
- R11: While reset is held, and after it is released, all outputs are zero until the first take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqLevel | input | 4 | Highest pending interrupt level |
| psIn | input | XLEN | Current status word |
| levelMask | input | NLEVEL*XLEN | Per-level source masks, level 1 in the lowest slice |
| intPending | input | XLEN | Pending sources |
| intEnable | input | XLEN | Enabled sources |
| pcIn | input | XLEN | Current PC |
| vecBase | input | XLEN | Run-time vector base |
| takenPulse | output | 1 | Entry performed this cycle |
| pcOut | output | XLEN | New PC |
| psOut | output | XLEN | New status word |
| savedPc | output | XLEN | Data for the saved-PC / double PC write |
| savedPs | output | XLEN | Data for the saved-status write |
| epcWe | output | NLEVEL | One-hot saved-PC write, bit k = level k+1 |
| epsWe | output | NLEVEL-1 | One-hot saved-status write, bit k = level k+2 |
| depcWe | output | 1 | Double-exception PC write |
| causeWe | output | 1 | Exception-cause write |
| causeOut | output | 6 | Exception-cause value |

## Verification
Each result is due exactly one clock edge after the inputs that cause it. The bench drives a vector at a falling edge, lets one rising edge pass, and samples every output at the next falling edge. It then drives an idle vector and checks, one edge later, that the strobes have cleared and the held data has not moved. Every combination of requested level (0 to 15), current level (0 to 15), exception-mode bit, user-mode bit and mask hit is swept. Two instances are driven with the same inputs: one uses the default configuration and the other disables relocation and the double-exception PC register.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int ILVL_W   = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;
  localparam int CAUSE_W  = 6;

  typedef struct packed {
    logic take;
    logic high;
    logic dbl;
    logic user;
  } entryCtl_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int NLEVEL = 7,
  parameter int XLEN   = 32
) (
  input  logic [ILVL_W-1:0]      reqLevel,
  input  logic [ILVL_W-1:0]      curLevel,
  input  logic                   excMode,
  input  logic                   userMode,
  input  logic [NLEVEL*XLEN-1:0] levelMask,
  input  logic [XLEN-1:0]        intPending,
  input  logic [XLEN-1:0]        intEnable,
  output entryCtl_t              ctl
);
  logic [NLEVEL:1] hitVec;
  logic [XLEN-1:0] live;

  assign live = intPending & intEnable;

  for (genvar g = 1; g <= NLEVEL; g++) begin : gHit
    assign hitVec[g] = |(levelMask[(g-1)*XLEN +: XLEN] & live);
  end

  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int i = 1; i <= NLEVEL; i++) begin
      if (reqLevel == ILVL_W'(i)) hit = hitVec[i];
    end
  end

  always_comb begin
    ctl.take = hit && (reqLevel > curLevel);
    ctl.high = reqLevel > ILVL_W'(1);
    ctl.dbl  = excMode;
    ctl.user = userMode;
  end
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int          NLEVEL        = 7,
  parameter int          XLEN          = 32,
  parameter bit          RELOC_EN      = 1'b1,
  parameter bit          HAS_DEPC      = 1'b1,
  parameter logic [31:0] RESET_VECBASE = 32'hD000_0000,
  parameter logic [31:0] HI_VEC_BASE   = 32'hD000_0180,
  parameter logic [31:0] VEC_STRIDE    = 32'h0000_0020,
  parameter logic [31:0] KERNEL_VEC    = 32'hD000_0300,
  parameter logic [31:0] USER_VEC      = 32'hD000_0340,
  parameter logic [31:0] DOUBLE_VEC    = 32'hD000_03C0,
  parameter logic [CAUSE_W-1:0] LVL1_CAUSE = 6'd4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  entryCtl_t           ctl,
  input  logic [ILVL_W-1:0]   reqLevel,
  input  logic [XLEN-1:0]     psIn,
  input  logic [XLEN-1:0]     pcIn,
  input  logic [XLEN-1:0]     vecBase,
  output logic                takenPulse,
  output logic [XLEN-1:0]     pcOut,
  output logic [XLEN-1:0]     psOut,
  output logic [XLEN-1:0]     savedPc,
  output logic [XLEN-1:0]     savedPs,
  output logic [NLEVEL-1:0]   epcWe,
  output logic [NLEVEL-2:0]   epsWe,
  output logic                depcWe,
  output logic                causeWe,
  output logic [CAUSE_W-1:0]  causeOut
);
  localparam logic [XLEN-1:0] EXCM_MASK = XLEN'(1) << EXCM_BIT;
  localparam logic [XLEN-1:0] ILVL_MASK = XLEN'((1 << ILVL_W) - 1);

  function automatic logic [XLEN-1:0] reloc(input logic [XLEN-1:0] v,
                                            input logic [XLEN-1:0] base);
    if (RELOC_EN) return v - XLEN'(RESET_VECBASE) + base;
    else          return v;
  endfunction

  logic [NLEVEL-1:0] lvlHot;
  for (genvar g = 0; g < NLEVEL; g++) begin : gHot
    assign lvlHot[g] = (reqLevel == ILVL_W'(g + 1));
  end

  logic [XLEN-1:0]   nPc, nPs, rawVec;
  logic [NLEVEL-1:0] nEpcWe;
  logic [NLEVEL-2:0] nEpsWe;
  logic              nDepcWe, nCauseWe;

  always_comb begin
    nEpcWe   = '0;
    nEpsWe   = '0;
    nDepcWe  = 1'b0;
    nCauseWe = 1'b0;
    if (ctl.high) begin
      nEpcWe = lvlHot;
      nEpsWe = lvlHot[NLEVEL-1:1];
      nPs    = (psIn & ~ILVL_MASK) | XLEN'(reqLevel) | EXCM_MASK;
      rawVec = XLEN'(HI_VEC_BASE) + (XLEN'(reqLevel) - XLEN'(2)) * XLEN'(VEC_STRIDE);
    end else begin
      nCauseWe = 1'b1;
      nPs      = psIn | EXCM_MASK;
      if (ctl.dbl) begin
        if (HAS_DEPC) nDepcWe   = 1'b1;
        else          nEpcWe[0] = 1'b1;
        rawVec = XLEN'(DOUBLE_VEC);
      end else begin
        nEpcWe[0] = 1'b1;
        rawVec    = ctl.user ? XLEN'(USER_VEC) : XLEN'(KERNEL_VEC);
      end
    end
    nPc = reloc(rawVec, vecBase);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      takenPulse <= 1'b0;
      pcOut      <= '0;
      psOut      <= '0;
      savedPc    <= '0;
      savedPs    <= '0;
      epcWe      <= '0;
      epsWe      <= '0;
      depcWe     <= 1'b0;
      causeWe    <= 1'b0;
      causeOut   <= '0;
    end else begin
      takenPulse <= ctl.take;
      epcWe      <= ctl.take ? nEpcWe : '0;
      epsWe      <= ctl.take ? nEpsWe : '0;
      depcWe     <= ctl.take & nDepcWe;
      causeWe    <= ctl.take & nCauseWe;
      if (ctl.take) begin
        pcOut   <= nPc;
        psOut   <= nPs;
        savedPc <= pcIn;
        savedPs <= psIn;
        if (nCauseWe) causeOut <= LVL1_CAUSE;
      end
    end
  end
endmodule

// File: rtl/irq_entry_top.sv
module irq_entry_top
  import irq_entry_pkg::*;
#(
  parameter int          NLEVEL        = 7,
  parameter int          XLEN          = 32,
  parameter bit          RELOC_EN      = 1'b1,
  parameter bit          HAS_DEPC      = 1'b1,
  parameter logic [31:0] RESET_VECBASE = 32'hD000_0000,
  parameter logic [31:0] HI_VEC_BASE   = 32'hD000_0180,
  parameter logic [31:0] VEC_STRIDE    = 32'h0000_0020,
  parameter logic [31:0] KERNEL_VEC    = 32'hD000_0300,
  parameter logic [31:0] USER_VEC      = 32'hD000_0340,
  parameter logic [31:0] DOUBLE_VEC    = 32'hD000_03C0,
  parameter logic [5:0]  LVL1_CAUSE    = 6'd4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             reqLevel,
  input  logic [XLEN-1:0]        psIn,
  input  logic [NLEVEL*XLEN-1:0] levelMask,
  input  logic [XLEN-1:0]        intPending,
  input  logic [XLEN-1:0]        intEnable,
  input  logic [XLEN-1:0]        pcIn,
  input  logic [XLEN-1:0]        vecBase,
  output logic                   takenPulse,
  output logic [XLEN-1:0]        pcOut,
  output logic [XLEN-1:0]        psOut,
  output logic [XLEN-1:0]        savedPc,
  output logic [XLEN-1:0]        savedPs,
  output logic [NLEVEL-1:0]      epcWe,
  output logic [NLEVEL-2:0]      epsWe,
  output logic                   depcWe,
  output logic                   causeWe,
  output logic [5:0]             causeOut
);
  entryCtl_t ctl;

  irq_entry_ctrl #(.NLEVEL(NLEVEL), .XLEN(XLEN)) u_ctrl (
    .reqLevel  (reqLevel),
    .curLevel  (psIn[ILVL_W-1:0]),
    .excMode   (psIn[EXCM_BIT]),
    .userMode  (psIn[UM_BIT]),
    .levelMask (levelMask),
    .intPending(intPending),
    .intEnable (intEnable),
    .ctl       (ctl)
  );

  irq_entry_dp #(
    .NLEVEL(NLEVEL), .XLEN(XLEN), .RELOC_EN(RELOC_EN), .HAS_DEPC(HAS_DEPC),
    .RESET_VECBASE(RESET_VECBASE), .HI_VEC_BASE(HI_VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE), .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC),
    .DOUBLE_VEC(DOUBLE_VEC), .LVL1_CAUSE(LVL1_CAUSE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqLevel(reqLevel), .psIn(psIn),
    .pcIn(pcIn), .vecBase(vecBase), .takenPulse(takenPulse), .pcOut(pcOut),
    .psOut(psOut), .savedPc(savedPc), .savedPs(savedPs), .epcWe(epcWe),
    .epsWe(epsWe), .depcWe(depcWe), .causeWe(causeWe), .causeOut(causeOut)
  );
endmodule

// File: rtl/irq_entry_sva.sv
module irq_entry_sva #(
  parameter int NLEVEL = 7,
  parameter int XLEN   = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           reqLevel,
  input logic [XLEN-1:0]      psIn,
  input logic                 takenPulse,
  input logic [XLEN-1:0]      pcOut,
  input logic [XLEN-1:0]      psOut,
  input logic [XLEN-1:0]      savedPs,
  input logic [NLEVEL-1:0]    epcWe,
  input logic [NLEVEL-2:0]    epsWe,
  input logic                 depcWe,
  input logic                 causeWe
);
  assert_level_above_R1: assert property (@(posedge clk) disable iff (!rst_n)
    takenPulse |-> ($past(reqLevel) > $past(psIn[3:0])));

  assert_quiet_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !takenPulse |-> (epcWe == '0 && epsWe == '0 && !depcWe && !causeWe));

  assert_hold_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !takenPulse |-> ($stable(pcOut) && $stable(psOut)));

  assert_single_pc_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
    takenPulse |-> (($countones(epcWe) + 32'(depcWe)) == 1));

  assert_status_bank_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(epsWe));

  assert_excm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    takenPulse |-> psOut[4]);

  assert_level_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (takenPulse && epsWe != '0) |-> (psOut[3:0] > savedPs[3:0]));

  assert_l1_no_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    causeWe |-> (epsWe == '0));
endmodule

bind irq_entry_top irq_entry_sva #(.NLEVEL(NLEVEL), .XLEN(XLEN)) u_sva (
  .clk(clk), .rst_n(rst_n), .reqLevel(reqLevel), .psIn(psIn),
  .takenPulse(takenPulse), .pcOut(pcOut), .psOut(psOut), .savedPs(savedPs),
  .epcWe(epcWe), .epsWe(epsWe), .depcWe(depcWe), .causeWe(causeWe)
);

// File: tb/tb_irq_entry_top.sv
module tb_irq_entry_top;
  localparam int NL = 7;
  localparam int XL = 32;
  localparam logic [31:0] RVB = 32'hD000_0000;
  localparam logic [31:0] VB  = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]       reqLevel = '0;
  logic [XL-1:0]    psIn = '0, intPending = '0, intEnable = '0, pcIn = '0;
  logic [XL-1:0]    vecBase = VB;
  logic [NL*XL-1:0] levelMask;

  logic [XL-1:0] pcA, psA, sPcA, sPsA, pcB, psB, sPcB, sPsB;
  logic [NL-1:0] eWeA, eWeB;
  logic [NL-2:0] sWeA, sWeB;
  logic tkA, tkB, dWeA, dWeB, cWeA, cWeB;
  logic [5:0] cA, cB;

  irq_entry_top dut (
    .clk(clk), .rst_n(rst_n), .reqLevel(reqLevel), .psIn(psIn), .levelMask(levelMask),
    .intPending(intPending), .intEnable(intEnable), .pcIn(pcIn), .vecBase(vecBase),
    .takenPulse(tkA), .pcOut(pcA), .psOut(psA), .savedPc(sPcA), .savedPs(sPsA),
    .epcWe(eWeA), .epsWe(sWeA), .depcWe(dWeA), .causeWe(cWeA), .causeOut(cA));

  irq_entry_top #(.RELOC_EN(1'b0), .HAS_DEPC(1'b0)) dutAlt (
    .clk(clk), .rst_n(rst_n), .reqLevel(reqLevel), .psIn(psIn), .levelMask(levelMask),
    .intPending(intPending), .intEnable(intEnable), .pcIn(pcIn), .vecBase(vecBase),
    .takenPulse(tkB), .pcOut(pcB), .psOut(psB), .savedPc(sPcB), .savedPs(sPsB),
    .epcWe(eWeB), .epsWe(sWeB), .depcWe(dWeB), .causeWe(cWeB), .causeOut(cB));

  for (genvar g = 1; g <= NL; g++) begin : gMask
    assign levelMask[(g-1)*XL +: XL] = (32'h1 << g) | (32'h1 << (g + 8));
  end

  int nTests = 0, nFail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // expected held state per instance: [0]=default, [1]=alternate
  logic [XL-1:0] hPc [2], hPs [2], hSPc [2], hSPs [2];
  logic [5:0]    hC [2];

  task automatic checkInst(input int k, input bit take, input int lvl, input bit excm, input bit um);
    logic tk, dW, cW; logic [XL-1:0] pc, ps, sPc, sPs; logic [NL-1:0] eW; logic [NL-2:0] sW;
    logic [5:0] c; logic [XL-1:0] raw, expPc, expPs; logic [NL-1:0] expE; logic [NL-2:0] expS;
    bit expD, expC, reloc, hasDepc; string tag;
    reloc = (k == 0); hasDepc = (k == 0);
    if (k == 0) begin tk=tkA; pc=pcA; ps=psA; sPc=sPcA; sPs=sPsA; eW=eWeA; sW=sWeA; dW=dWeA; cW=cWeA; c=cA; end
    else        begin tk=tkB; pc=pcB; ps=psB; sPc=sPcB; sPs=sPsB; eW=eWeB; sW=sWeB; dW=dWeB; cW=cWeB; c=cB; end
    eq(take ? "R1 taken" : "R2 not taken", 64'(tk), 64'(take));
    expE = '0; expS = '0; expD = 0; expC = 0;
    if (take) begin
      if (lvl > 1) begin
        tag = "R4/R5/R6 high level";
        expE[lvl-1] = 1'b1; expS[lvl-2] = 1'b1;
        raw = 32'hD000_0180 + 32'(lvl - 2) * 32'h20;
        expPs = (psIn & ~32'hF) | 32'(lvl) | 32'h10;
      end else begin
        expC = 1; expPs = psIn | 32'h10;
        if (excm) begin
          tag = "R8 double";
          if (hasDepc) expD = 1; else expE[0] = 1'b1;
          raw = 32'hD000_03C0;
        end else begin
          tag = "R9 level1";
          expE[0] = 1'b1;
          raw = um ? 32'hD000_0340 : 32'hD000_0300;
        end
        hC[k] = 6'd4;
      end
      expPc = reloc ? raw - RVB + VB : raw;
      hPc[k] = expPc; hPs[k] = expPs; hSPc[k] = pcIn; hSPs[k] = psIn;
    end else tag = "R2 hold";
    eq({tag, " epcWe"}, 64'(eW), 64'(expE));
    eq({tag, " epsWe"}, 64'(sW), 64'(expS));
    eq({tag, " depcWe"}, 64'(dW), 64'(expD));
    eq({tag, " R7 causeWe"}, 64'(cW), 64'(expC));
    eq({tag, " R10 pcOut"}, 64'(pc), 64'(hPc[k]));
    eq({tag, " psOut"}, 64'(ps), 64'(hPs[k]));
    eq({tag, " savedPc"}, 64'(sPc), 64'(hSPc[k]));
    eq({tag, " savedPs"}, 64'(sPs), 64'(hSPs[k]));
    eq({tag, " R7 causeOut"}, 64'(c), 64'(hC[k]));
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin hPc[k]=0; hPs[k]=0; hSPc[k]=0; hSPs[k]=0; hC[k]=0; end
    repeat (3) @(negedge clk);
    eq("R11 reset taken", 64'(tkA), 0);
    eq("R11 reset pcOut", 64'(pcA), 0);
    eq("R11 reset psOut", 64'(psA), 0);
    eq("R11 reset strobes", 64'({eWeA, sWeA, dWeA, cWeA}), 0);
    eq("R11 reset cause", 64'(cB), 0);
    rst_n = 1'b1;
    @(negedge clk);
    eq("R11 after release", 64'({tkA, pcA, eWeB}), 0);
    for (int lvl = 0; lvl < 16; lvl++)
      for (int cur = 0; cur < 16; cur++)
        for (int m = 0; m < 8; m++) begin
          bit excm, um, hit, take;
          excm = m[0]; um = m[1]; hit = m[2];
          reqLevel   = 4'(lvl);
          psIn       = 32'hA5A5_0000 | 32'(cur) | (32'(excm) << 4) | (32'(um) << 5) | 32'h40;
          pcIn       = 32'h1000_0000 + 32'((lvl * 16 + cur) * 8 + m) * 4;
          intPending = 32'h1 << lvl;
          intEnable  = hit ? 32'hFFFF_FFFF : ~(32'h1 << lvl);
          // R1: level range, strict compare, masked pending&enabled
          take = hit && lvl >= 1 && lvl <= NL && lvl > cur;
          @(negedge clk);
          checkInst(0, take, lvl, excm, um);
          checkInst(1, take, lvl, excm, um);
          reqLevel = 4'd0;
          intPending = 32'hFFFF_FFFF;
          @(negedge clk);
          // R3: pulse lasts one cycle; R2: idle vector has no effect
          checkInst(0, 1'b0, 0, 1'b0, 1'b0);
          checkInst(1, 1'b0, 0, 1'b0, 1'b0);
        end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule